// File: doc/BRIEF.md
# Gas Sample Classifier (PCA Projection and Decision Tree)

This block classifies one gas sample from a 16-channel sensor array. A start pulse captures the sixteen readings. Each reading is a signed Q8.8 value. The block subtracts a stored per-channel mean from each reading. It then projects the centred vector onto a set of stored eigenvectors, handling four channels per cycle. This produces principal-component scores. Finally it walks a small threshold tree over those scores and reports a class code: 1 for carbon monoxide, 2 for ethanol and 3 for hydrogen.

A mode input selects drift compensation. In that mode each channel's feature is its reading minus a supplied baseline, and four components are computed instead of three. A single write port loads the means, eigenvector coefficients and tree nodes. That port is honoured only while the block is idle.

Top module: `gas_pca_tree_classifier`

## Requirements
- R1: In normal mode (`drift_mode`=0) the block computes three scores. Score k is the sum over the 16 channels of (reading − mean) × eigen[k][ch], arithmetic-shifted right by 8 and saturated to signed 24 bits. The baseline input has no effect in this mode.
- R2: In drift mode (`drift_mode`=1, captured at start) the feature of each channel is reading − baseline − mean, and four scores (k = 0..3) are computed.
- R3: Coefficient writes use `coef_sel` as follows. With 0, a mean is written: `coef_addr[3:0]` is the channel and the value is `coef_data[15:0]`. With 1, an eigen coefficient is written at address k×16+channel, with the value in `coef_data[15:0]`. With 2, a tree node is written at index `coef_addr[2:0]`.
- R4: A node word has these fields: [23:0] signed threshold, [25:24] component index, [29:26] left target, [33:30] right target and [34] valid. The walk starts at node 0. It takes the right target when score[component] > threshold (signed), and the left target otherwise, so equality goes left.
- R5: A target with bit 3 set is a leaf whose class is in bits [1:0]. Otherwise bits [2:0] name the next node. Codes are 1 = CO, 2 = ethanol, 3 = H2.
- R6: `done` is a one-cycle pulse. It is seen 4×P + N clock edges after the edge that samples `start`, where P is 3 or 4 components and N is the number of nodes evaluated.
- R7: `class_code` changes only in the cycle `done` is high, and holds its value between results, including while a new sample is being processed.
- R8: `start` is ignored while `busy` is high: it neither restarts the block nor changes the pending result.
- R9: Coefficient writes are ignored while `busy` is high.
- R10: A node with the valid bit clear, or one naming a component that the current mode does not compute (index 3 in normal mode), ends the walk with class code 0.
- R11: A walk that evaluates 8 nodes without reaching a leaf ends with class code 0, after exactly 8 tree cycles.
- R12: Scores beyond the signed 24-bit range clamp to 0x7FFFFF or −0x800000 rather than wrapping.
- R13: After reset `busy`, `done` and `class_code` are 0, and all coefficient storage is cleared, so every node is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin classification of the presented sample |
| drift_mode | input | 1 | 1 = baseline-delta features and four components |
| sample_in | input | 256 | 16 signed Q8.8 readings, channel 0 in bits [15:0] |
| baseline_in | input | 256 | 16 signed Q8.8 baselines, same layout |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Target store: 0 mean, 1 eigen, 2 tree node |
| coef_addr | input | 6 | Store address |
| coef_data | input | 35 | Write data |
| busy | output | 1 | A sample is being processed |
| done | output | 1 | One-cycle completion pulse |
| class_code | output | 2 | Result: 0 error, 1 CO, 2 ethanol, 3 H2 |

## Verification
The hardest situation to reach from the ports is score saturation. Getting there requires an extreme reading, an extreme mean of opposite sign and a near-full-scale eigen coefficient on the same four channels. The bench loads that combination into component 0 and sets the root threshold one step inside the clamp limit. A clamped score and a wrapped score then send the walk to different leaves, so the class code shows which one the block produced. The runaway walk is reached by writing two nodes that point at each other, and the latency of that run is checked as well as its code.

// File: rtl/gas_pca_tree_classifier.sv
module gas_pca_tree_classifier #(
  parameter int NCH   = 16,
  parameter int W     = 16,
  parameter int LANES = 4,
  parameter int MAXPC = 4,
  parameter int ACCW  = 40,
  parameter int SCW   = 24,
  parameter int NODES = 8,
  parameter int SHIFT = 8,
  parameter int CDW   = SCW + $clog2(MAXPC) + 2 * ($clog2(NODES) + 1) + 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic                              drift_mode,
  input  logic [NCH*W-1:0]                  sample_in,
  input  logic [NCH*W-1:0]                  baseline_in,
  input  logic                              coef_we,
  input  logic [1:0]                        coef_sel,
  input  logic [$clog2(MAXPC*NCH)-1:0]      coef_addr,
  input  logic [CDW-1:0]                    coef_data,
  output logic                              busy,
  output logic                              done,
  output logic [1:0]                        class_code
);
  localparam int BEATS = NCH / LANES;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int FW    = W + 1;
  localparam int PRW   = FW + 1 + W;
  localparam int PW    = $clog2(MAXPC);
  localparam int NW    = $clog2(NODES);
  localparam int TW    = NW + 1;
  localparam int CHW   = $clog2(NCH);
  localparam int NODEW = SCW + PW + 2 * TW + 1;
  localparam logic signed [ACCW-1:0] SMAX = {{(ACCW-SCW+1){1'b0}}, {(SCW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] SMIN = {{(ACCW-SCW+1){1'b1}}, {(SCW-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_PROJ, S_TREE} st_t;

  st_t                     state_q;
  logic                    mode_q, done_q;
  logic [1:0]              class_q;
  logic [NCH*FW-1:0]       feat_q, feat_d;
  logic [NCH*W-1:0]        mean_q;
  logic [MAXPC*NCH*W-1:0]  eig_q;
  logic [NODES*NODEW-1:0]  node_q;
  logic [MAXPC*SCW-1:0]    score_q;
  logic signed [ACCW-1:0]  acc_q, acc_next, beat_sum, shifted;
  logic signed [SCW-1:0]   sat_val;
  logic [BW-1:0]           beat_q;
  logic [PW-1:0]           pc_q, last_pc;
  logic [NW-1:0]           cur_q, steps_q;
  logic signed [PRW-1:0]   prod [LANES];

  for (genvar g = 0; g < NCH; g++) begin : g_feat
    logic signed [W-1:0] s, b;
    assign s = sample_in[g*W +: W];
    assign b = drift_mode ? baseline_in[g*W +: W] : '0;
    assign feat_d[g*FW +: FW] = FW'(s) - FW'(b);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [FW-1:0] x;
    logic signed [W-1:0]  m, e;
    logic signed [FW:0]   c;
    assign x = feat_q[(int'(beat_q) * LANES + l) * FW +: FW];
    assign m = mean_q[(int'(beat_q) * LANES + l) * W +: W];
    assign e = eig_q[(int'(pc_q) * NCH + int'(beat_q) * LANES + l) * W +: W];
    assign c = x - m;
    assign prod[l] = c * e;
  end

  always_comb begin
    beat_sum = '0;
    for (int l = 0; l < LANES; l++) beat_sum = beat_sum + prod[l];
  end

  assign acc_next = acc_q + beat_sum;
  assign shifted  = acc_next >>> SHIFT;
  assign sat_val  = (shifted > SMAX) ? SMAX[SCW-1:0] :
                    (shifted < SMIN) ? SMIN[SCW-1:0] : shifted[SCW-1:0];
  assign last_pc  = mode_q ? PW'(MAXPC - 1) : PW'(MAXPC - 2);

  logic [NODEW-1:0]        nw;
  logic signed [SCW-1:0]   thr, sel;
  logic [PW-1:0]           comp;
  logic [TW-1:0]           tgt;
  logic                    node_ok, go_right;

  assign nw       = node_q[int'(cur_q) * NODEW +: NODEW];
  assign thr      = nw[SCW-1:0];
  assign comp     = nw[SCW +: PW];
  assign sel      = score_q[int'(comp) * SCW +: SCW];
  assign go_right = sel > thr;
  assign tgt      = go_right ? nw[SCW+PW+TW +: TW] : nw[SCW+PW +: TW];
  assign node_ok  = nw[NODEW-1] &&
                    ({1'b0, comp} < (mode_q ? (PW+1)'(MAXPC) : (PW+1)'(MAXPC - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      class_q <= '0;
      feat_q  <= '0;
      mean_q  <= '0;
      eig_q   <= '0;
      node_q  <= '0;
      score_q <= '0;
      acc_q   <= '0;
      beat_q  <= '0;
      pc_q    <= '0;
      cur_q   <= '0;
      steps_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (coef_we && state_q == S_IDLE) begin
        case (coef_sel)
          2'd0:    mean_q[int'(coef_addr[CHW-1:0]) * W +: W] <= coef_data[W-1:0];
          2'd1:    eig_q[int'(coef_addr) * W +: W] <= coef_data[W-1:0];
          2'd2:    node_q[int'(coef_addr[NW-1:0]) * NODEW +: NODEW] <= coef_data[NODEW-1:0];
          default: ;
        endcase
      end
      case (state_q)
        S_IDLE: if (start) begin
          feat_q  <= feat_d;
          mode_q  <= drift_mode;
          acc_q   <= '0;
          beat_q  <= '0;
          pc_q    <= '0;
          state_q <= S_PROJ;
        end
        S_PROJ: begin
          if (beat_q == BW'(BEATS - 1)) begin
            score_q[int'(pc_q) * SCW +: SCW] <= sat_val;
            acc_q  <= '0;
            beat_q <= '0;
            if (pc_q == last_pc) begin
              state_q <= S_TREE;
              cur_q   <= '0;
              steps_q <= '0;
            end else begin
              pc_q <= pc_q + 1'b1;
            end
          end else begin
            acc_q  <= acc_next;
            beat_q <= beat_q + 1'b1;
          end
        end
        S_TREE: begin
          if (!node_ok || tgt[TW-1] || steps_q == NW'(NODES - 1)) begin
            class_q <= (node_ok && tgt[TW-1]) ? tgt[1:0] : 2'd0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cur_q   <= tgt[NW-1:0];
            steps_q <= steps_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy       = state_q != S_IDLE;
  assign done       = done_q;
  assign class_code = class_q;

  assert_done_after_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(state_q == S_TREE));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_class_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(class_q));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(feat_q) && $stable(mode_q)));
  assert_coef_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mean_q) && $stable(eig_q) && $stable(node_q)));
  assert_bad_node_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TREE && !node_ok) |=> (done_q && class_q == 2'd0));
  assert_walk_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TREE && node_ok && !tgt[TW-1] && steps_q == NW'(NODES - 1))
      |=> (done_q && class_q == 2'd0));
  assert_proj_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROJ) |-> (pc_q <= last_pc));
endmodule

// File: tb/gas_pca_tree_classifier_tb.sv
module gas_pca_tree_classifier_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         drift_mode = 1'b0;
  logic [255:0] sample_in = '0;
  logic [255:0] baseline_in = '0;
  logic         coef_we = 1'b0;
  logic [1:0]   coef_sel = '0;
  logic [5:0]   coef_addr = '0;
  logic [34:0]  coef_data = '0;
  logic         busy, done;
  logic [1:0]   class_code;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gas_pca_tree_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .drift_mode(drift_mode),
    .sample_in(sample_in), .baseline_in(baseline_in), .coef_we(coef_we),
    .coef_sel(coef_sel), .coef_addr(coef_addr), .coef_data(coef_data),
    .busy(busy), .done(done), .class_code(class_code));

  // row: [138] mode, [137:74] group readings, [73:10] group baselines, [9:8] class, [7:0] latency
  localparam logic [138:0] VEC [8] = '{
    {1'b0, 64'h0100_0100_0000_0000, 64'h0, 2'd3, 8'd14},
    {1'b0, 64'h0100_0080_0000_0000, 64'h0, 2'd1, 8'd14},
    {1'b0, 64'h0040_0000_0010_0000, 64'h0, 2'd2, 8'd14},
    {1'b0, 64'h0000_0000_FFF0_0000, 64'h0, 2'd0, 8'd15},
    {1'b1, 64'h0000_0000_FFF0_0020, 64'h0, 2'd1, 8'd19},
    {1'b1, 64'h0, 64'h0000_0000_0000_0010, 2'd3, 8'd19},
    {1'b1, 64'h0100_0100_0000_0040, 64'h0100_0000_0000_0000, 2'd1, 8'd19},
    {1'b0, 64'h0100_0100_0000_0040, 64'h0100_0000_0000_0000, 2'd3, 8'd14}
  };

  function automatic logic [255:0] grp(input logic [63:0] g);
    logic [255:0] r;
    for (int ch = 0; ch < 16; ch++) r[ch*16 +: 16] = g[(3 - ch/4)*16 +: 16];
    return r;
  endfunction

  function automatic logic [3:0] leaf(input logic [1:0] c);
    return {2'b10, c};
  endfunction

  function automatic logic [3:0] nd(input logic [2:0] i);
    return {1'b0, i};
  endfunction

  function automatic logic [34:0] node(input logic [3:0] rgt, input logic [3:0] lft,
                                       input logic [1:0] comp, input logic [23:0] thr);
    return {1'b1, rgt, lft, comp, thr};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [5:0] addr, input logic [34:0] data);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = sel; coef_addr = addr; coef_data = data;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic run(input logic mode, input logic [255:0] smp, input logic [255:0] bl,
                     input bit hold_chk, output logic [1:0] cls, output int lat);
    logic [1:0] prior;
    prior = class_code;
    @(negedge clk);
    drift_mode = mode; sample_in = smp; baseline_in = bl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (hold_chk && lat == 5) chk("R7 class held while busy", class_code, prior);
      if (done) break;
      if (lat > 200) begin
        chk("R6 done timeout", 0, 1);
        break;
      end
    end
    cls = class_code;
    @(negedge clk);
    chk("R6 done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] cls;
    int lat;
    int dones;
    repeat (3) @(negedge clk);
    chk("R13 busy after reset", busy, 0);
    chk("R13 done after reset", done, 0);
    chk("R13 class after reset", class_code, 0);
    rst_n = 1'b1;

    // R13: node storage cleared -> root invalid -> code 0
    run(1'b0, '0, '0, 0, cls, lat);
    chk("R13 cleared tree gives code 0", cls, 0);

    // R3: coefficient load through the write port
    wr(2'd0, 6'd0, 35'h0100);
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 4; c++) wr(2'd1, 6'(k*16 + k*4 + c), 35'h0100);
    wr(2'd2, 6'd0, node(nd(1), nd(2), 2'd0, 24'h0));
    wr(2'd2, 6'd1, node(leaf(3), leaf(1), 2'd1, 24'h000200));
    wr(2'd2, 6'd2, node(leaf(2), nd(3), 2'd2, 24'h0));
    wr(2'd2, 6'd3, node(leaf(1), leaf(3), 2'd3, 24'h0));

    // R1 R2 R4 R5 R6 R10: table walk
    for (int i = 0; i < 8; i++) begin
      run(VEC[i][138], grp(VEC[i][137:74]), grp(VEC[i][73:10]), 0, cls, lat);
      chk($sformatf("R1 R2 R4 R5 class row %0d", i), cls, VEC[i][9:8]);
      chk($sformatf("R6 latency row %0d", i), lat, VEC[i][7:0]);
    end

    // R8 R9: second start and a node write while busy
    @(negedge clk);
    drift_mode = 1'b0; sample_in = grp(VEC[0][137:74]); baseline_in = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    repeat (2) @(negedge clk);
    sample_in = grp(VEC[2][137:74]); start = 1'b1;
    coef_we = 1'b1; coef_sel = 2'd2; coef_addr = 6'd0;
    coef_data = node(nd(1), nd(2), 2'd0, 24'h7FFFFF);
    @(negedge clk);
    start = 1'b0; coef_we = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R8 one done for two starts", dones, 1);
    chk("R8 result of first sample", class_code, 3);

    run(1'b0, grp(VEC[2][137:74]), '0, 1, cls, lat);
    chk("R7 new result after hold", cls, 2);
    run(1'b0, grp(VEC[0][137:74]), '0, 0, cls, lat);
    chk("R9 busy write ignored", cls, 3);

    // R12: positive clamp
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, 6'(c), 35'h8000);
      wr(2'd1, 6'(c), 35'h7FFF);
    end
    wr(2'd2, 6'd0, node(leaf(2), leaf(1), 2'd0, 24'h7FFFFE));
    run(1'b0, grp(64'h7FFF_0000_0000_0000), '0, 0, cls, lat);
    chk("R12 positive saturation", cls, 2);

    // R12: negative clamp
    for (int c = 0; c < 4; c++) wr(2'd0, 6'(c), 35'h7FFF);
    wr(2'd2, 6'd0, node(leaf(2), leaf(1), 2'd0, 24'h800001));
    run(1'b0, grp(64'h8000_0000_0000_0000), '0, 0, cls, lat);
    chk("R12 negative saturation", cls, 1);

    // R11: two nodes pointing at each other
    wr(2'd2, 6'd0, node(nd(1), nd(1), 2'd0, 24'h0));
    wr(2'd2, 6'd1, node(nd(0), nd(0), 2'd1, 24'h0));
    run(1'b0, '0, '0, 0, cls, lat);
    chk("R11 runaway walk code", cls, 0);
    chk("R11 runaway walk latency", lat, 20);

    // R10: target is a never-written node
    wr(2'd2, 6'd0, node(nd(5), nd(5), 2'd0, 24'h0));
    run(1'b1, '0, '0, 0, cls, lat);
    chk("R10 invalid node code", cls, 0);
    chk("R10 invalid node latency", lat, 18);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule